// File: doc/BRIEF.md
# Queued Four-Slot Memory Copy Engine

The engine copies blocks of 32-bit words from one memory region to another over an AHB-Lite master port. Software programs up to four transfer slots through a small register port. Each slot holds a source address, a destination address and a byte count. Software arms any subset of the slots and then writes the start bit. The engine walks the slots from slot 0 to slot 3 and skips the unarmed ones. No processor help is needed between slots.

Each word moves as one single-beat read followed by one single-beat write. There are no bursts. When the queue ends, a sticky interrupt is raised. The queue can end normally, on a bad slot setting or on a bus error. A cycle timer measures how long the engine stayed busy, so software can work out throughput. Copies longer than four slots need software to reload the slots and start the engine again after the interrupt. The engine never reuses a slot by itself.

Top module: `dma_queue_engine`

## Requirements
- R1: Four slots sit at register offsets 0x40 + 16·n (n = 0..3). Within a slot, source is at +0x0, destination at +0x4, byte count at +0x8 and the arm bit is bit 0 of +0xC. After a start the engine runs the armed slots strictly in ascending slot order and skips unarmed slots.
- R2: Each word is fetched by one read beat from the source address. The fetched word is then written by one write beat to the destination address. Both beats use HTRANS NONSEQ (2'b10), HSIZE word (3'b010) and HBURST single (3'b000). Both addresses step by 4 after each word. HTRANS is IDLE (2'b00) otherwise.
- R3: The engine waits on hready_i in every address phase and every data phase. While an address phase is stalled, haddr_o, hwrite_o and htrans_o hold their values.
- R4: When the last word of a slot has been written, that slot's arm bit reads back 0.
- R5: An armed slot is rejected when any of these holds: its byte count is zero, its byte count is not a multiple of 4, its byte count exceeds MAX_BYTES, or its source or destination address is not word aligned. Rejection sets status bit 2 and ends the queue with no bus beat. The rejected slot and all later slots keep their arm bits.
- R6: An AHB ERROR response on a read or a write data phase sets status bit 3 and ends the queue at once. The failing slot and all later slots keep their arm bits and issue no further beats.
- R7: Every end of queue (normal, rejected or bus error) sets status bit 1 and drives irq_o high. Both stay high until software writes 1 to status bit 1 at offset 0x04. Status bits 2 and 3 are also cleared by writing 1 to them. Status bit 0 reads 1 while the engine is busy.
- R8: Writing 1 to bit 0 of offset 0x00 starts the engine when it is idle. The same write is ignored while the engine is busy.
- R9: The timer at offset 0x08 is cleared on start. It counts once for every cycle the engine is busy, from the cycle after the start write through the final cycle of the queue. It holds its value after the interrupt is raised.
- R10: After reset, status reads 0, the timer reads 0, all arm bits read 0, irq_o is low and HTRANS is IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| irq_o | output | 1 | Queue-finished interrupt, sticky |
| haddr_o | output | 32 | AHB address |
| htrans_o | output | 2 | AHB transfer type |
| hwrite_o | output | 1 | AHB write flag |
| hsize_o | output | 3 | AHB transfer size |
| hburst_o | output | 3 | AHB burst type |
| hwdata_o | output | 32 | AHB write data |
| hrdata_i | input | 32 | AHB read data |
| hready_i | input | 1 | AHB ready |
| hresp_i | input | 1 | AHB error response |

## Verification
The bench builds the engine with MAX_BYTES = 64 and the default 32-bit timer. At that size a full slot is 16 words and a 68-byte slot crosses the limit, so both the largest legal slot and the over-size rejection are tested within a few hundred cycles. The slave model in the bench adds 0 to 2 wait states on each data phase, so the timer value can be predicted exactly as picks plus (4 + 2·waits) per word plus one closing cycle. Addresses whose bits 15:12 are 0xE answer with ERROR, which reaches both the read-error and write-error abort paths.

// File: rtl/dma_queue_pkg.sv
package dma_queue_pkg;
  localparam int NUM_DESC = 4;
  localparam int IDX_W    = $clog2(NUM_DESC);

  typedef enum logic [2:0] {
    S_IDLE, S_PICK, S_RADDR, S_RDATA, S_WADDR, S_WDATA, S_DONE
  } seq_state_e;

  localparam logic [1:0] HTRANS_IDLE   = 2'b00;
  localparam logic [1:0] HTRANS_NONSEQ = 2'b10;
  localparam logic [2:0] HSIZE_WORD    = 3'b010;
  localparam logic [2:0] HBURST_SINGLE = 3'b000;

  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_STAT  = 8'h04;
  localparam logic [7:0] OFS_TIMER = 8'h08;
  localparam logic [1:0] DESC_BANK = 2'b01;

  localparam int STAT_BUSY = 0;
  localparam int STAT_IRQ  = 1;
  localparam int STAT_CFG  = 2;
  localparam int STAT_BUS  = 3;
endpackage

// File: rtl/dma_desc_regs.sv
module dma_desc_regs
  import dma_queue_pkg::*;
#(
  parameter int CNT_W = 17,
  parameter int TMR_W = 32
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             reg_wr_i,
  input  logic [7:0]                       reg_addr_i,
  input  logic [31:0]                      reg_wdata_i,
  output logic [31:0]                      reg_rdata_o,
  input  logic                             busy_i,
  input  logic [TMR_W-1:0]                 tmr_i,
  input  logic                             clr_valid_i,
  input  logic [IDX_W-1:0]                 clr_idx_i,
  input  logic                             set_irq_i,
  input  logic                             set_cfg_err_i,
  input  logic                             set_bus_err_i,
  output logic                             start_o,
  output logic                             irq_o,
  output logic [NUM_DESC-1:0][31:0]        d_src_o,
  output logic [NUM_DESC-1:0][31:0]        d_dst_o,
  output logic [NUM_DESC-1:0][CNT_W-1:0]   d_cnt_o,
  output logic [NUM_DESC-1:0]              d_valid_o
);
  logic             bank_hit, wr_ctrl, wr_stat;
  logic [IDX_W-1:0] sel_idx;
  logic [1:0]       fld;
  logic             irq_q, cfg_q, bus_q;

  assign bank_hit = (reg_addr_i[7:6] == DESC_BANK);
  assign sel_idx  = reg_addr_i[4 +: IDX_W];
  assign fld      = reg_addr_i[3:2];
  assign wr_ctrl  = reg_wr_i && (reg_addr_i == OFS_CTRL);
  assign wr_stat  = reg_wr_i && (reg_addr_i == OFS_STAT);
  assign start_o  = wr_ctrl && reg_wdata_i[0] && !busy_i;
  assign irq_o    = irq_q;

  for (genvar g = 0; g < NUM_DESC; g++) begin : g_slot
    logic [31:0]      src_r, dst_r;
    logic [CNT_W-1:0] cnt_r;
    logic             vld_r;
    logic             hit;
    assign hit = reg_wr_i && bank_hit && (sel_idx == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        src_r <= '0;
        dst_r <= '0;
        cnt_r <= '0;
        vld_r <= 1'b0;
      end else begin
        if (hit) begin
          case (fld)
            2'd0:    src_r <= reg_wdata_i;
            2'd1:    dst_r <= reg_wdata_i;
            2'd2:    cnt_r <= reg_wdata_i[CNT_W-1:0];
            default: vld_r <= reg_wdata_i[0];
          endcase
        end
        // completion wins over a concurrent software write
        if (clr_valid_i && clr_idx_i == IDX_W'(g)) vld_r <= 1'b0;
      end
    end

    assign d_src_o[g]   = src_r;
    assign d_dst_o[g]   = dst_r;
    assign d_cnt_o[g]   = cnt_r;
    assign d_valid_o[g] = vld_r;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      cfg_q <= 1'b0;
      bus_q <= 1'b0;
    end else begin
      if (wr_stat && reg_wdata_i[STAT_IRQ]) irq_q <= 1'b0;
      if (wr_stat && reg_wdata_i[STAT_CFG]) cfg_q <= 1'b0;
      if (wr_stat && reg_wdata_i[STAT_BUS]) bus_q <= 1'b0;
      if (set_irq_i)     irq_q <= 1'b1;
      if (set_cfg_err_i) cfg_q <= 1'b1;
      if (set_bus_err_i) bus_q <= 1'b1;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (bank_hit) begin
      case (fld)
        2'd0:    reg_rdata_o = d_src_o[sel_idx];
        2'd1:    reg_rdata_o = d_dst_o[sel_idx];
        2'd2:    reg_rdata_o = 32'(d_cnt_o[sel_idx]);
        default: reg_rdata_o = {31'b0, d_valid_o[sel_idx]};
      endcase
    end else begin
      case (reg_addr_i)
        OFS_STAT:  reg_rdata_o = {28'b0, bus_q, cfg_q, irq_q, busy_i};
        OFS_TIMER: reg_rdata_o = 32'(tmr_i);
        default:   reg_rdata_o = '0;
      endcase
    end
  end

  // R4
  arm_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_valid_i |=> d_valid_o[$past(clr_idx_i)] == 1'b0);

  // R7
  irq_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q && !(wr_stat && reg_wdata_i[STAT_IRQ]) |=> irq_q);
endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
  import dma_queue_pkg::*;
#(
  parameter int MAX_BYTES = 65536,
  parameter int CNT_W     = 17
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           start_i,
  input  logic [NUM_DESC-1:0][31:0]      d_src_i,
  input  logic [NUM_DESC-1:0][31:0]      d_dst_i,
  input  logic [NUM_DESC-1:0][CNT_W-1:0] d_cnt_i,
  input  logic [NUM_DESC-1:0]            d_valid_i,
  output logic                           busy_o,
  output logic                           clr_valid_o,
  output logic [IDX_W-1:0]               clr_idx_o,
  output logic                           set_irq_o,
  output logic                           set_cfg_err_o,
  output logic                           set_bus_err_o,
  output logic [31:0]                    haddr_o,
  output logic [1:0]                     htrans_o,
  output logic                           hwrite_o,
  output logic [2:0]                     hsize_o,
  output logic [2:0]                     hburst_o,
  output logic [31:0]                    hwdata_o,
  input  logic [31:0]                    hrdata_i,
  input  logic                           hready_i,
  input  logic                           hresp_i
);
  localparam logic [CNT_W-1:0] MAX_CNT  = CNT_W'(MAX_BYTES);
  localparam logic [CNT_W-1:0] WORD_CNT = CNT_W'(4);

  seq_state_e       state;
  logic [IDX_W-1:0] idx;
  logic [31:0]      cur_src, cur_dst, data_q;
  logic [CNT_W-1:0] remain;
  logic             cfg_bad, last, last_word, beat_ok, beat_err;

  assign last      = (idx == IDX_W'(NUM_DESC - 1));
  assign last_word = (remain == WORD_CNT);
  assign cfg_bad   = (d_cnt_i[idx] == '0) || (d_cnt_i[idx][1:0] != 2'b00) ||
                     (d_cnt_i[idx] > MAX_CNT) ||
                     (d_src_i[idx][1:0] != 2'b00) || (d_dst_i[idx][1:0] != 2'b00);
  assign beat_ok   = hready_i && !hresp_i;
  assign beat_err  = hready_i && hresp_i;

  assign busy_o        = (state != S_IDLE);
  assign set_irq_o     = (state == S_DONE);
  assign set_cfg_err_o = (state == S_PICK) && d_valid_i[idx] && cfg_bad;
  assign set_bus_err_o = ((state == S_RDATA) || (state == S_WDATA)) && beat_err;
  assign clr_valid_o   = (state == S_WDATA) && beat_ok && last_word;
  assign clr_idx_o     = idx;

  assign htrans_o = ((state == S_RADDR) || (state == S_WADDR)) ? HTRANS_NONSEQ : HTRANS_IDLE;
  assign hwrite_o = (state == S_WADDR);
  assign haddr_o  = (state == S_WADDR) ? cur_dst : cur_src;
  assign hsize_o  = HSIZE_WORD;
  assign hburst_o = HBURST_SINGLE;
  assign hwdata_o = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state   <= S_IDLE;
      idx     <= '0;
      cur_src <= '0;
      cur_dst <= '0;
      remain  <= '0;
      data_q  <= '0;
    end else begin
      case (state)
        S_IDLE: if (start_i) begin
          idx   <= '0;
          state <= S_PICK;
        end
        S_PICK: begin
          if (d_valid_i[idx]) begin
            if (cfg_bad) state <= S_DONE;
            else begin
              cur_src <= d_src_i[idx];
              cur_dst <= d_dst_i[idx];
              remain  <= d_cnt_i[idx];
              state   <= S_RADDR;
            end
          end else if (last) state <= S_DONE;
          else idx <= idx + IDX_W'(1);
        end
        S_RADDR: if (hready_i) state <= S_RDATA;
        S_RDATA: if (beat_err) state <= S_DONE;
                 else if (beat_ok) begin
                   data_q <= hrdata_i;
                   state  <= S_WADDR;
                 end
        S_WADDR: if (hready_i) state <= S_WDATA;
        S_WDATA: if (beat_err) state <= S_DONE;
                 else if (beat_ok) begin
                   if (last_word) begin
                     if (last) state <= S_DONE;
                     else begin
                       idx   <= idx + IDX_W'(1);
                       state <= S_PICK;
                     end
                   end else begin
                     remain  <= remain - WORD_CNT;
                     cur_src <= cur_src + 32'd4;
                     cur_dst <= cur_dst + 32'd4;
                     state   <= S_RADDR;
                   end
                 end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R3
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (htrans_o == HTRANS_NONSEQ) && !hready_i |=>
      (htrans_o == HTRANS_NONSEQ) && $stable(haddr_o) && $stable(hwrite_o));

  // R5
  cfg_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_cfg_err_o |=> (htrans_o == HTRANS_IDLE) && set_irq_o);

  // R6
  bus_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_bus_err_o |=> (htrans_o == HTRANS_IDLE) && set_irq_o);
endmodule

// File: rtl/dma_cycle_timer.sv
module dma_cycle_timer #(
  parameter int TMR_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             busy_i,
  output logic [TMR_W-1:0] cnt_o
);
  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (start_i) cnt_q <= '0;
    else if (busy_i)  cnt_q <= cnt_q + TMR_W'(1);
  end

  assign cnt_o = cnt_q;

  // R9
  timer_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i && !start_i |=> $stable(cnt_q));
endmodule

// File: rtl/dma_queue_engine.sv
module dma_queue_engine
  import dma_queue_pkg::*;
#(
  parameter int MAX_BYTES = 65536,
  parameter int TMR_W     = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_wr_i,
  input  logic [7:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        irq_o,
  output logic [31:0] haddr_o,
  output logic [1:0]  htrans_o,
  output logic        hwrite_o,
  output logic [2:0]  hsize_o,
  output logic [2:0]  hburst_o,
  output logic [31:0] hwdata_o,
  input  logic [31:0] hrdata_i,
  input  logic        hready_i,
  input  logic        hresp_i
);
  localparam int CNT_W = $clog2(MAX_BYTES) + 1;

  logic                           busy, start, clr_valid, set_irq, set_cfg, set_bus;
  logic [IDX_W-1:0]               clr_idx;
  logic [TMR_W-1:0]               tmr;
  logic [NUM_DESC-1:0][31:0]      d_src, d_dst;
  logic [NUM_DESC-1:0][CNT_W-1:0] d_cnt;
  logic [NUM_DESC-1:0]            d_valid;

  dma_desc_regs #(.CNT_W(CNT_W), .TMR_W(TMR_W)) u_regs (
    .clk_i, .rst_ni, .reg_wr_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .busy_i(busy), .tmr_i(tmr), .clr_valid_i(clr_valid), .clr_idx_i(clr_idx),
    .set_irq_i(set_irq), .set_cfg_err_i(set_cfg), .set_bus_err_i(set_bus),
    .start_o(start), .irq_o, .d_src_o(d_src), .d_dst_o(d_dst),
    .d_cnt_o(d_cnt), .d_valid_o(d_valid)
  );

  dma_xfer_fsm #(.MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W)) u_fsm (
    .clk_i, .rst_ni, .start_i(start),
    .d_src_i(d_src), .d_dst_i(d_dst), .d_cnt_i(d_cnt), .d_valid_i(d_valid),
    .busy_o(busy), .clr_valid_o(clr_valid), .clr_idx_o(clr_idx),
    .set_irq_o(set_irq), .set_cfg_err_o(set_cfg), .set_bus_err_o(set_bus),
    .haddr_o, .htrans_o, .hwrite_o, .hsize_o, .hburst_o, .hwdata_o,
    .hrdata_i, .hready_i, .hresp_i
  );

  dma_cycle_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk_i, .rst_ni, .start_i(start), .busy_i(busy), .cnt_o(tmr)
  );

  // R8
  restart_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && reg_wr_i && (reg_addr_i == OFS_CTRL) && reg_wdata_i[0] |=> tmr != '0);
endmodule

// File: tb/dma_queue_engine_test.sv
`timescale 1ns/1ps
module dma_queue_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic [31:0] haddr, hwdata, hrdata;
  logic [1:0]  htrans;
  logic        hwrite, hready, hresp;
  logic [2:0]  hsize, hburst;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dma_queue_engine #(.MAX_BYTES(64), .TMR_W(32)) uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq),
    .haddr_o(haddr), .htrans_o(htrans), .hwrite_o(hwrite), .hsize_o(hsize),
    .hburst_o(hburst), .hwdata_o(hwdata), .hrdata_i(hrdata),
    .hready_i(hready), .hresp_i(hresp)
  );

  // ---------------- AHB slave model with wait states and error region
  logic [31:0] mem [1024];
  logic        pending, ph_write, ph_err, preset, mon_clr;
  logic [9:0]  ph_idx;
  int          ws = 0, wcnt;
  int          rd_beats, wr_beats;
  logic        alt_bad, mon_any, last_w, attr_bad;

  function automatic logic [31:0] pat(int i);
    return 32'h13579BDF ^ (32'(i) * 32'h00010203);
  endfunction

  assign hready = !pending || (wcnt == 0);
  assign hresp  = pending && ph_err;
  assign hrdata = mem[ph_idx];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0; ph_write <= 1'b0; ph_err <= 1'b0; ph_idx <= '0; wcnt <= 0;
    end else begin
      if (preset) for (int i = 0; i < 1024; i++) mem[i] <= pat(i);
      if (pending && wcnt != 0) wcnt <= wcnt - 1;
      else if (pending) begin
        if (ph_write && !ph_err) mem[ph_idx] <= hwdata;
        pending <= 1'b0;
      end
      if (htrans[1] && hready) begin
        pending  <= 1'b1;
        ph_write <= hwrite;
        ph_idx   <= haddr[11:2];
        ph_err   <= (haddr[15:12] == 4'hE);
        wcnt     <= ws;
      end
    end
  end

  // beat monitor: counts accepted address phases, checks read/write alternation and attributes
  always @(posedge clk) begin
    if (mon_clr) begin
      rd_beats <= 0; wr_beats <= 0; alt_bad <= 1'b0; mon_any <= 1'b0;
      last_w <= 1'b0; attr_bad <= 1'b0;
    end else if (htrans != 2'b00 && hready) begin
      if (htrans != 2'b10 || hsize != 3'b010 || hburst != 3'b000) attr_bad <= 1'b1;
      if (hwrite) wr_beats <= wr_beats + 1; else rd_beats <= rd_beats + 1;
      if ((mon_any && last_w == hwrite) || (!mon_any && hwrite)) alt_bad <= 1'b1;
      last_w  <= hwrite;
      mon_any <= 1'b1;
    end
  end

  // ---------------- helpers
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [7:0] slot_ofs(int s, int f);
    return 8'(8'h40 + s * 16 + f * 4);
  endfunction

  task automatic arm(input int s, input logic [31:0] src, input logic [31:0] dst, input int bytes);
    wr(slot_ofs(s, 0), src);
    wr(slot_ofs(s, 1), dst);
    wr(slot_ofs(s, 2), 32'(bytes));
    wr(slot_ofs(s, 3), 32'd1);
  endtask

  task automatic prep(input int w);
    @(negedge clk);
    ws = w; preset = 1'b1; mon_clr = 1'b1;
    @(negedge clk);
    preset = 1'b0; mon_clr = 1'b0;
  endtask

  task automatic wait_irq(input string tag);
    int n = 0;
    while (!irq && n < 5000) begin @(negedge clk); n++; end
    chk({tag, " irq raised"}, 32'(irq), 32'd1);
  endtask

  task automatic mem_cmp(input string tag, input int dst_b, input int ref_b, input int words);
    int bad = 0;
    for (int k = 0; k < words; k++)
      if (mem[(dst_b >> 2) + k] !== pat((ref_b >> 2) + k)) bad++;
    chk(tag, 32'(bad), 32'd0);
  endtask

  // slot, src, dst, bytes, wait states, kind (0 ok, 1 rejected, 2 read error, 3 write error), timer
  typedef struct packed {
    logic [1:0]  slot;
    logic [15:0] src;
    logic [15:0] dst;
    logic [7:0]  bytes;
    logic [1:0]  ws;
    logic [1:0]  kind;
    logic [7:0]  tmr;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 16'h0000, 16'h0400, 8'd16, 2'd0, 2'd0, 8'd21},
    '{2'd2, 16'h0100, 16'h0800, 8'd64, 2'd1, 2'd0, 8'd101},
    '{2'd3, 16'h0040, 16'h0600, 8'd4,  2'd2, 2'd0, 8'd13},
    '{2'd1, 16'h0002, 16'h0400, 8'd8,  2'd0, 2'd1, 8'd3},
    '{2'd0, 16'h0000, 16'h0400, 8'd68, 2'd0, 2'd1, 8'd2},
    '{2'd0, 16'h0000, 16'h0400, 8'd0,  2'd0, 2'd1, 8'd2},
    '{2'd1, 16'h0000, 16'h0400, 8'd6,  2'd0, 2'd1, 8'd3},
    '{2'd2, 16'hE000, 16'h0400, 8'd8,  2'd1, 2'd2, 8'd7},
    '{2'd1, 16'h0300, 16'h0402, 8'd8,  2'd0, 2'd1, 8'd3},
    '{2'd3, 16'h0200, 16'hE000, 8'd4,  2'd1, 2'd3, 8'd11}
  };

  initial begin
    logic [31:0] v, v2;
    preset = 1'b0; mon_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    rd(8'h04, v); chk("R10 status after reset", v, 32'h0);
    rd(8'h08, v); chk("R10 timer after reset", v, 32'h0);
    chk("R10 irq after reset", 32'(irq), 32'h0);
    chk("R10 htrans after reset", 32'(htrans), 32'h0);
    for (int s = 0; s < 4; s++) begin
      rd(slot_ofs(s, 3), v); chk("R10 arm bit after reset", v, 32'h0);
    end

    // table of single-slot runs: R1 R2 R4 R5 R6 R7 R9
    for (int i = 0; i < NV; i++) begin
      vec_t t = VEC[i];
      int words = (t.bytes / 4 > 0) ? int'(t.bytes) / 4 : 1;
      logic [31:0] st_exp;
      prep(int'(t.ws));
      arm(int'(t.slot), 32'(t.src), 32'(t.dst), int'(t.bytes));
      wr(8'h00, 32'd1);
      wait_irq("R7 table");
      st_exp = (t.kind == 2'd0) ? 32'h2 : (t.kind == 2'd1) ? 32'h6 : 32'hA;
      rd(8'h04, v); chk($sformatf("R7 R5 R6 status vec%0d", i), v, st_exp);
      rd(8'h08, v); chk($sformatf("R9 timer vec%0d", i), v, 32'(t.tmr));
      rd(slot_ofs(int'(t.slot), 3), v);
      chk($sformatf("R4 arm bit vec%0d", i), v, (t.kind == 2'd0) ? 32'h0 : 32'h1);
      if (t.dst[15:12] != 4'hE)
        mem_cmp($sformatf("R1 R2 data vec%0d", i), int'(t.dst),
                (t.kind == 2'd0) ? int'(t.src) : int'(t.dst), words);
      chk($sformatf("R2 read beats vec%0d", i), 32'(rd_beats),
          (t.kind == 2'd0) ? 32'(words) : (t.kind == 2'd1) ? 32'd0 : 32'd1);
      chk($sformatf("R2 write beats vec%0d", i), 32'(wr_beats),
          (t.kind == 2'd0) ? 32'(words) : (t.kind == 2'd3) ? 32'd1 : 32'd0);
      chk($sformatf("R2 alternation vec%0d", i), 32'(alt_bad), 32'd0);
      chk($sformatf("R2 beat attributes vec%0d", i), 32'(attr_bad), 32'd0);
      wr(slot_ofs(int'(t.slot), 3), 32'd0);
      wr(8'h04, 32'hE);
      chk($sformatf("R7 irq cleared vec%0d", i), 32'(irq), 32'd0);
    end

    // R1 four-slot queue, order seen through two slots sharing one destination
    prep(0);
    arm(0, 32'h000, 32'hA00, 8);
    arm(1, 32'h100, 32'hA00, 8);
    arm(2, 32'h200, 32'hB00, 8);
    arm(3, 32'h300, 32'hC00, 8);
    wr(8'h00, 32'd1);
    wait_irq("R1 queue");
    mem_cmp("R1 slot1 ran after slot0", 32'hA00, 32'h100, 2);
    mem_cmp("R1 slot2 data", 32'hB00, 32'h200, 2);
    mem_cmp("R1 slot3 data", 32'hC00, 32'h300, 2);
    rd(8'h08, v); chk("R9 timer four slots", v, 32'd37);
    for (int s = 0; s < 4; s++) begin
      rd(slot_ofs(s, 3), v); chk("R4 arm cleared after queue", v, 32'h0);
    end
    chk("R2 beats four slots", 32'(rd_beats + wr_beats), 32'd16);
    wr(8'h04, 32'hE);

    // R6 write error in slot1 stops slot2
    prep(1);
    arm(0, 32'h000, 32'hA00, 4);
    arm(1, 32'h100, 32'hE000, 4);
    arm(2, 32'h200, 32'hB00, 4);
    wr(8'h00, 32'd1);
    wait_irq("R6 mid-queue");
    rd(8'h04, v); chk("R6 status bus error", v, 32'hA);
    mem_cmp("R6 slot0 done", 32'hA00, 32'h000, 1);
    mem_cmp("R6 slot2 not run", 32'hB00, 32'hB00, 1);
    rd(slot_ofs(0, 3), v); chk("R6 slot0 arm cleared", v, 32'h0);
    rd(slot_ofs(1, 3), v); chk("R6 slot1 arm kept", v, 32'h1);
    rd(slot_ofs(2, 3), v); chk("R6 slot2 arm kept", v, 32'h1);
    rd(8'h08, v); chk("R9 timer bus abort", v, 32'd15);
    wr(slot_ofs(1, 3), 32'd0);
    wr(slot_ofs(2, 3), 32'd0);
    wr(8'h04, 32'hE);

    // R8 start while busy is ignored
    prep(0);
    arm(0, 32'h000, 32'h400, 64);
    wr(8'h00, 32'd1);
    repeat (10) @(negedge clk);
    rd(8'h04, v); chk("R7 busy bit while running", v & 32'h1, 32'h1);
    wr(8'h00, 32'd1);
    wait_irq("R8 restart");
    rd(8'h08, v); chk("R8 timer not restarted", v, 32'd69);
    chk("R8 beats not repeated", 32'(rd_beats), 32'd16);

    // R7 sticky interrupt, R9 timer hold
    repeat (20) @(negedge clk);
    chk("R7 irq still pending", 32'(irq), 32'd1);
    wr(8'h04, 32'h0);
    chk("R7 irq kept on zero write", 32'(irq), 32'd1);
    rd(8'h08, v2); chk("R9 timer held", v2, 32'd69);
    wr(8'h04, 32'h2);
    chk("R7 irq cleared by one", 32'(irq), 32'd0);

    // R1 empty queue
    prep(0);
    wr(8'h00, 32'd1);
    wait_irq("R1 empty");
    rd(8'h04, v); chk("R1 empty status", v, 32'h2);
    rd(8'h08, v); chk("R9 timer empty queue", v, 32'd5);
    chk("R1 empty no beats", 32'(rd_beats + wr_beats), 32'd0);
    wr(8'h04, 32'hE);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule